// File: doc/BRIEF.md
# Tagged ADC Result FIFO

This block sits between a scan sequencer driving a 12-bit converter and a host that reads results one register word at a time. Each result the sequencer delivers is stored with a single identity bit derived from the channel it came from. A read strobe pops the oldest entry and returns it as a 16-bit word. The word's top bits report live buffer status: a full flag and an empty flag.

The block also polices the order of results inside a scan. A scan start pulse selects the scan kind. Results are then admitted only in that scan's fixed channel order. Results that arrive out of order, from an input that is not enabled, or outside any scan are discarded. The host side has no write path, so the buffer cannot be written from there.

Top module: `adc_tag_fifo`

## Requirements
- R1: After reset, `rd_word[15]` (full) is 0 and `rd_word[14]` (empty) is 1.
- R2: In every read word, bit 13 is 0 and bit 12 is the identity bit. The channel codes on `wr_chan` are 0 = battery, 1 = first auxiliary, 2 = second auxiliary and 3 = temperature. The identity bit is 1 for codes 1 and 3, and 0 for codes 0 and 2.
- R3: Accepted results are returned in arrival order, right-justified in `rd_word[11:0]`. The popped entry appears on `rd_word` in the cycle after the cycle in which `rd_stb` is sampled high.
- R4: `rd_word[15]` is 1 exactly when 64 entries are unread. A result accepted by the scan order while the buffer is full is dropped, and the stored entries are left unchanged.
- R5: `rd_word[14]` is 1 exactly when no entry is unread. It is already 1 in the word that returns the last unread entry.
- R6: A read while the buffer is empty returns the empty flag set and a zero result and identity bit, and it moves no pointer.
- R7: A write and a read in the same cycle on a non-empty, non-full buffer are both performed, and the occupancy stays the same.
- R8: Auto scan is a `scan_start` pulse with `scan_port` = 0, using `scan_mask` bit 0 = first auxiliary, bit 1 = second auxiliary and bit 2 = temperature. Results are then accepted only in the order first auxiliary, second auxiliary, temperature, skipping inputs that are not enabled. Any other result is dropped, and so is every result after the scan completes or before any scan starts.
- R9: Port scan is a `scan_start` pulse with `scan_port` = 1. Results are then accepted only in the order battery, first auxiliary, second auxiliary, and a temperature or out-of-order result is dropped.
- R10: A `scan_start` pulse restarts the sequence and discards a write strobe in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| scan_start | input | 1 | Begins a new scan sequence |
| scan_port | input | 1 | Scan kind at start: 1 port scan, 0 auto scan |
| scan_mask | input | 3 | Auto scan enables: bit0 first aux, bit1 second aux, bit2 temperature |
| wr_stb | input | 1 | Result strobe from the sequencer |
| wr_chan | input | 2 | Channel code of the result |
| wr_data | input | 12 | Conversion result |
| rd_stb | input | 1 | Host read: pops the head entry |
| rd_word | output | 16 | {full, empty, 0, identity, result} |

## Verification
The checks assume that `rd_stb` and `wr_stb` are single-cycle strobes sampled at the rising edge. They also assume that the sequencer never changes `wr_chan` or `wr_data` during a strobe cycle. The properties on occupancy take `scan_start` and strobes to be driven from the clock domain of the block. The stimulus changes every input only between edges and pulses each strobe for exactly one cycle. It deliberately includes out-of-order and disabled channels, writes outside a scan, reads of an empty buffer and writes into a full one.

// File: rtl/adc_tag_fifo_pkg.sv
package adc_tag_fifo_pkg;
    localparam int RES_W  = 12;
    localparam int WORD_W = 16;
    localparam int CH_W   = 2;
    localparam int NCH    = 1 << CH_W;
    localparam int MASK_W = 3;

    typedef enum logic [CH_W-1:0] {
        CH_BATT = 2'd0,
        CH_AUX1 = 2'd1,
        CH_AUX2 = 2'd2,
        CH_TEMP = 2'd3
    } chan_e;

    typedef struct packed {
        logic             ident;
        logic [RES_W-1:0] value;
    } entry_t;

    localparam logic [NCH-1:0] PORT_SET = 4'b0111;
endpackage

// File: rtl/adc_scan_gate.sv
module adc_scan_gate
    import adc_tag_fifo_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scan_start,
    input  logic              scan_port,
    input  logic [MASK_W-1:0] scan_mask,
    input  logic              wr_stb,
    input  logic [CH_W-1:0]   wr_chan,
    output logic              accept
);
    typedef struct packed {
        logic [NCH-1:0] pend;
    } gate_t;

    gate_t s_q, s_d;
    logic [NCH-1:0] next_one;

    always_comb begin
        s_d      = s_q;
        next_one = s_q.pend & (~s_q.pend + {{(NCH-1){1'b0}}, 1'b1});
        accept   = wr_stb && !scan_start && next_one[wr_chan];
        if (scan_start) begin
            s_d.pend = scan_port ? PORT_SET : {scan_mask, 1'b0};
        end else if (accept) begin
            s_d.pend = s_q.pend & ~next_one;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/adc_result_store.sv
module adc_result_store
    import adc_tag_fifo_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_req,
    input  entry_t        push_entry,
    input  logic          pop_req,
    output entry_t        head,
    output logic          popped,
    output logic [CW-1:0] occ
);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][RES_W:0] mem;
        logic [AW-1:0]             wp;
        logic [AW-1:0]             rp;
        logic [CW-1:0]             cnt;
    } store_t;

    store_t s_q, s_d;
    logic   do_push;

    always_comb begin
        s_d     = s_q;
        do_push = push_req && (s_q.cnt != FULL_CNT);
        popped  = pop_req && (s_q.cnt != '0);
        if (do_push) begin
            s_d.mem[s_q.wp] = push_entry;
            s_d.wp          = s_q.wp + 1'b1;
        end
        if (popped) begin
            s_d.rp = s_q.rp + 1'b1;
        end
        if (do_push && !popped)      s_d.cnt = s_q.cnt + 1'b1;
        else if (popped && !do_push) s_d.cnt = s_q.cnt - 1'b1;
        head = s_q.mem[s_q.rp];
        occ  = s_q.cnt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/adc_tag_fifo.sv
module adc_tag_fifo
    import adc_tag_fifo_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scan_start,
    input  logic              scan_port,
    input  logic [MASK_W-1:0] scan_mask,
    input  logic              wr_stb,
    input  logic [CH_W-1:0]   wr_chan,
    input  logic [RES_W-1:0]  wr_data,
    input  logic              rd_stb,
    output logic [WORD_W-1:0] rd_word
);
    localparam int CW = $clog2(DEPTH) + 1;
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    typedef struct packed {
        entry_t out;
    } top_t;

    top_t          t_q, t_d;
    logic          wr_acc;
    logic          popped;
    entry_t        head;
    entry_t        new_entry;
    logic [CW-1:0] occ;

    adc_scan_gate u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .scan_start (scan_start),
        .scan_port  (scan_port),
        .scan_mask  (scan_mask),
        .wr_stb     (wr_stb),
        .wr_chan    (wr_chan),
        .accept     (wr_acc)
    );

    adc_result_store #(.DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_req   (wr_acc),
        .push_entry (new_entry),
        .pop_req    (rd_stb),
        .head       (head),
        .popped     (popped),
        .occ        (occ)
    );

    always_comb begin
        t_d             = t_q;
        new_entry.ident = wr_chan[0];
        new_entry.value = wr_data;
        if (rd_stb) begin
            t_d.out = popped ? head : '0;
        end
        rd_word = {(occ == FULL_CNT), (occ == '0), 1'b0, t_q.out};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end
endmodule

// File: rtl/adc_tag_fifo_chk.sv
module adc_tag_fifo_chk #(
    parameter int DEPTH = 64,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          accept,
    input logic          rd_stb,
    input logic [CW-1:0] occ,
    input logic [15:0]   rd_word
);
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_word[13] == 1'b0);

    a_r4_drop_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !rd_stb && rd_word[15] |=> $stable(occ) && rd_word[15]);

    a_r5_empty_with_last: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb && !accept && occ == CW'(1) |=> rd_word[14]);

    a_r6_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb && !accept && rd_word[14] |=> $stable(occ) && rd_word[14] && rd_word[12:0] == 13'd0);

    a_r7_both_keep_count: assert property (@(posedge clk) disable iff (!rst_n)
        accept && rd_stb && !rd_word[15] && !rd_word[14] |=> $stable(occ));

    a_r4_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_word[15] && rd_word[14]));
endmodule

bind adc_tag_fifo adc_tag_fifo_chk #(.DEPTH(DEPTH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept  (wr_acc),
    .rd_stb  (rd_stb),
    .occ     (occ),
    .rd_word (rd_word)
);

// File: tb/adc_tag_fifo_test.sv
`timescale 1ns/1ps
module adc_tag_fifo_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scan_start = 1'b0, scan_port = 1'b0;
    logic [2:0]  scan_mask = 3'b0;
    logic        wr_stb = 1'b0;
    logic [1:0]  wr_chan = 2'b0;
    logic [11:0] wr_data = 12'b0;
    logic        rd_stb = 1'b0;
    logic [15:0] rd_word;

    int checks = 0, failures = 0;
    bit done = 0;

    logic [12:0] sb[$];
    logic [3:0]  pend = 4'b0;
    logic [12:0] ent;
    logic [15:0] expw;
    bit          full_b, was_empty;
    logic [11:0] seed = 12'h100;

    always #5 clk = ~clk;

    adc_tag_fifo uut (.*);

    function automatic int first_set(logic [3:0] p);
        for (int i = 0; i < 4; i++) if (p[i]) return i;
        return 4;
    endfunction

    task automatic check(bit ok, string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Scoreboard model: pushes expected entries, pops and compares on each read.
    always @(posedge clk) begin
        if (!rst_n) begin
            sb.delete();
            pend = 4'b0;
        end else begin
            full_b = (sb.size() == 64);
            was_empty = 1'b0;
            ent = 13'b0;
            if (rd_stb) begin
                was_empty = (sb.size() == 0);
                if (!was_empty) ent = sb.pop_front();
            end
            if (scan_start) pend = scan_port ? 4'b0111 : {scan_mask, 1'b0};
            else if (wr_stb && first_set(pend) == int'(wr_chan)) begin
                pend[wr_chan] = 1'b0;
                if (!full_b) sb.push_back({wr_chan[0], wr_data});
            end
            if (rd_stb) begin
                expw = {sb.size() == 64, sb.size() == 0, 1'b0, ent};
                #3;
                if (was_empty)
                    check(rd_word == expw, "R6 empty read", rd_word, expw);
                else begin
                    check(rd_word[11:0] == expw[11:0], "R3 result order", rd_word, expw);
                    check(rd_word[13:12] == expw[13:12], "R2 identity/reserved", rd_word, expw);
                    check(rd_word[15:14] == expw[15:14], "R5 flags in read word", rd_word, expw);
                end
            end
        end
    end

    task automatic drive(bit st, bit pm, logic [2:0] m, bit w, logic [1:0] ch, logic [11:0] d, bit r);
        @(negedge clk);
        scan_start = st; scan_port = pm; scan_mask = m;
        wr_stb = w; wr_chan = ch; wr_data = d; rd_stb = r;
        @(posedge clk);
        #1;
        scan_start = 0; wr_stb = 0; rd_stb = 0;
    endtask

    task automatic start(bit pm, logic [2:0] m);
        drive(1, pm, m, 0, 0, 0, 0);
    endtask

    task automatic put(logic [1:0] ch);
        seed = seed + 12'h0a7;
        drive(0, 0, 0, 1, ch, seed, 0);
    endtask

    task automatic get();
        drive(0, 0, 0, 0, 0, 0, 1);
    endtask

    task automatic flags(bit f, bit e, string req);
        #2;
        check(rd_word[15] == f && rd_word[14] == e, req, rd_word, {f, e, 14'b0});
    endtask

    initial begin
        #1_000_000;
        failures++;
        $display("FAIL watchdog expired");
        if (!done) $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #2;
        // R1 reset flags
        checks++;
        if (rd_word[15] !== 1'b0 || rd_word[14] !== 1'b1) begin
            failures++;
            $display("FAIL R1 reset actual=%h expected=full0 empty1", rd_word);
        end

        // R8 writes before any scan are dropped
        put(2'd1);
        flags(0, 1, "R8 no scan active");

        // R8 auto scan, all enabled
        start(0, 3'b111);
        put(2'd1); put(2'd2); put(2'd3);
        put(2'd1);   // past end of scan: dropped
        flags(0, 0, "R8 auto all");
        get(); get(); get();
        flags(0, 1, "R5 empty after last");

        // R8 auto scan, first aux and temperature only
        start(0, 3'b101);
        put(2'd3); put(2'd1); put(2'd2); put(2'd3);
        get(); get();
        flags(0, 1, "R8 auto mask");

        // R9 port scan order
        start(1, 3'b000);
        put(2'd1); put(2'd0); put(2'd3); put(2'd1); put(2'd2);
        get(); get(); get();

        // R6 read of empty buffer
        get();
        flags(0, 1, "R6 pointers kept");
        get();

        // R10 start with write in same cycle: write dropped
        drive(1, 1, 3'b000, 1, 2'd0, 12'h5a5, 0);
        flags(0, 1, "R10 write at start dropped");
        put(2'd0);
        get();

        // R7 simultaneous write and read
        start(1, 3'b000);
        put(2'd0);
        seed = seed + 12'h011;
        drive(0, 0, 0, 1, 2'd1, seed, 1);
        flags(0, 0, "R7 count kept");
        get();
        flags(0, 1, "R7 final empty");

        // R4 fill to 64, then overflow
        for (int s = 0; s < 22; s++) begin
            start(1, 3'b000);
            put(2'd0); put(2'd1); put(2'd2);
        end
        flags(1, 0, "R4 full flag");
        start(0, 3'b010);
        put(2'd2);
        flags(1, 0, "R4 still full after drop");
        for (int k = 0; k < 64; k++) get();
        flags(0, 1, "R5 drained");

        repeat (3) @(posedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule